// File: doc/BRIEF.md
# Radio time-code pulse classifier

This block turns a stream of measured carrier-drop lengths from a long-wave time-signal receiver into complete minute frames. Each length arrives with a one-cycle strobe and is counted in 25 ms ticks. The block sorts every length into one of five classes:

- too short to be valid;
- a data 0;
- a data 1;
- the minute gap;
- a length that belongs to no window.

Data pulses are written into a working register at a running bit position. When the last bit of a frame is written, the frame is moved to an output buffer and a ready flag goes up.

A consumer reads the 64-bit buffer once the ready flag is set, then pulses the clear input. The measurement of the pulse length is done upstream. Decoding of the time and date fields and parity checking are done downstream.

Top module: `tcode_pulse_decoder`

## Requirements
- R1: While reset is high at a clock edge, the output buffer, the ready flag, the bit position and the working register all clear to zero by the following cycle.
- R2: A strobed length of 3, 4 or 5 ticks writes a 0 at the current bit position, then advances the position by one.
- R3: A strobed length of 7, 8 or 9 ticks writes a 1 at the current bit position, then advances the position by one.
- R4: A strobed length of 0, 1 or 2 ticks writes no bit and returns the bit position to zero.
- R5: A strobed length of 40 to 83 ticks inclusive (the minute gap) writes no bit and returns the bit position to zero.
- R6: A strobed length of 6 ticks, of 10 to 39 ticks, or of more than 83 ticks writes no bit and keeps the bit position unchanged.
- R7: Frame bit n, counted from the first data bit after a position reset, appears at output bit frame_buf[n]. This is byte n/8 at bit n mod 8, least significant bit first. Output bits 59 to 63 read 0.
- R8: The strobe that writes bit 58 updates frame_buf and sets frame_ready on the same clock edge. That strobe also returns the bit position to zero. frame_buf changes at no other time.
- R9: frame_ready stays set until frame_ack is high at a clock edge, and then it clears. If a frame completes on the same edge as frame_ack, the flag is set.
- R10: With the strobe low, the buffer stays the same and the bit position does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| len_valid | input | 1 | One-cycle strobe qualifying len_ticks |
| len_ticks | input | 16 | Measured pulse length in 25 ms ticks |
| frame_ack | input | 1 | One-cycle clear of frame_ready |
| frame_buf | output | 64 | Last completed frame, bit n at position n |
| frame_ready | output | 1 | A new frame is in frame_buf |

## Verification
All effects of a strobe land on the clock edge that samples it, including the buffer copy and the flag set from the final bit. A frame_ack also takes effect on that edge. The bench therefore drives each stimulus on a falling edge, lets exactly one rising edge pass, and compares both outputs on the next falling edge. The bit position is not a port, so it is checked through later frames. Any stray advance or reset of the position shifts every later bit of the next buffer, and the reference model follows the position on every strobe.

// File: rtl/tcode_pkg.sv
package tcode_pkg;

  // Pulse classes produced by the window comparator
  typedef enum logic [2:0] {
    PK_NONE  = 3'd0,  // no strobe this cycle
    PK_SHORT = 3'd1,  // below the data-0 window
    PK_ZERO  = 3'd2,
    PK_ONE   = 3'd3,
    PK_GAP   = 3'd4,  // minute marker
    PK_STRAY = 3'd5   // outside every window
  } pulse_kind_e;

  function automatic logic kind_is_data(input pulse_kind_e k);
    return (k == PK_ZERO) || (k == PK_ONE);
  endfunction

  function automatic logic kind_restarts(input pulse_kind_e k);
    return (k == PK_SHORT) || (k == PK_GAP);
  endfunction

endpackage

// File: rtl/tcode_classify.sv
module tcode_classify
  import tcode_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int ZERO_MIN = 3,
  parameter int ZERO_MAX = 5,
  parameter int ONE_MIN  = 7,
  parameter int ONE_MAX  = 9,
  parameter int GAP_MIN  = 40,
  parameter int GAP_MAX  = 83
) (
  input  logic             strobe,
  input  logic [LEN_W-1:0] len,
  output pulse_kind_e      kind
);

  localparam logic [LEN_W-1:0] L_ZMIN = LEN_W'(ZERO_MIN);
  localparam logic [LEN_W-1:0] L_ZMAX = LEN_W'(ZERO_MAX);
  localparam logic [LEN_W-1:0] L_OMIN = LEN_W'(ONE_MIN);
  localparam logic [LEN_W-1:0] L_OMAX = LEN_W'(ONE_MAX);
  localparam logic [LEN_W-1:0] L_GMIN = LEN_W'(GAP_MIN);
  localparam logic [LEN_W-1:0] L_GMAX = LEN_W'(GAP_MAX);

  logic in_short, in_zero, in_one, in_gap;

  always_comb begin
    in_short = (len < L_ZMIN);
    in_zero  = (len >= L_ZMIN) && (len <= L_ZMAX);
    in_one   = (len >= L_OMIN) && (len <= L_OMAX);
    in_gap   = (len >= L_GMIN) && (len <= L_GMAX);
  end

  always_comb begin
    if (!strobe)       kind = PK_NONE;
    else if (in_short) kind = PK_SHORT;
    else if (in_zero)  kind = PK_ZERO;
    else if (in_one)   kind = PK_ONE;
    else if (in_gap)   kind = PK_GAP;
    else               kind = PK_STRAY;
  end

endmodule

// File: rtl/tcode_assemble.sv
module tcode_assemble
  import tcode_pkg::*;
#(
  parameter int FRAME_BITS = 59,
  parameter int BUF_W      = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  pulse_kind_e      kind,
  output logic             frame_done,
  output logic [BUF_W-1:0] frame_word
);

  localparam int                IDX_W = $clog2(FRAME_BITS + 1);
  localparam logic [IDX_W-1:0]  LAST  = IDX_W'(FRAME_BITS - 1);

  logic [IDX_W-1:0]      pos_q;
  logic [FRAME_BITS-1:0] work_q;
  logic [FRAME_BITS-1:0] work_d;
  logic                  is_data;
  logic                  bit_val;

  always_comb begin
    is_data = kind_is_data(kind);
    bit_val = (kind == PK_ONE);
  end

  // One write-enable per frame bit
  for (genvar i = 0; i < FRAME_BITS; i++) begin : g_bit
    logic hit;
    assign hit       = is_data && (pos_q == IDX_W'(i));
    assign work_d[i] = hit ? bit_val : work_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
    end else begin
      work_q <= work_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (is_data) begin
      pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end else if (kind_restarts(kind)) begin
      pos_q <= '0;
    end
  end

  assign frame_done = is_data && (pos_q == LAST);

  if (BUF_W > FRAME_BITS) begin : g_pad
    assign frame_word = {{(BUF_W - FRAME_BITS){1'b0}}, work_d};
  end else begin : g_nopad
    assign frame_word = work_d;
  end

endmodule

// File: rtl/tcode_frame_out.sv
module tcode_frame_out #(
  parameter int BUF_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BUF_W-1:0] word,
  input  logic             ack,
  output logic [BUF_W-1:0] buf_q,
  output logic             ready_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
    end else if (load) begin
      buf_q <= word;
    end
  end

  // A completing frame takes priority over a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
    end else if (load) begin
      ready_q <= 1'b1;
    end else if (ack) begin
      ready_q <= 1'b0;
    end
  end

endmodule

// File: rtl/tcode_pulse_decoder.sv
module tcode_pulse_decoder
  import tcode_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int FRAME_BITS = 59,
  parameter int BUF_W      = 64,
  parameter int ZERO_MIN   = 3,
  parameter int ZERO_MAX   = 5,
  parameter int ONE_MIN    = 7,
  parameter int ONE_MAX    = 9,
  parameter int GAP_MIN    = 40,
  parameter int GAP_MAX    = 83
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             len_valid,
  input  logic [LEN_W-1:0] len_ticks,
  input  logic             frame_ack,
  output logic [BUF_W-1:0] frame_buf,
  output logic             frame_ready
);

  pulse_kind_e      kind;
  logic             done;
  logic [BUF_W-1:0] word;

  tcode_classify #(
    .LEN_W   (LEN_W),
    .ZERO_MIN(ZERO_MIN), .ZERO_MAX(ZERO_MAX),
    .ONE_MIN (ONE_MIN),  .ONE_MAX (ONE_MAX),
    .GAP_MIN (GAP_MIN),  .GAP_MAX (GAP_MAX)
  ) u_cls (
    .strobe(len_valid),
    .len   (len_ticks),
    .kind  (kind)
  );

  tcode_assemble #(
    .FRAME_BITS(FRAME_BITS),
    .BUF_W     (BUF_W)
  ) u_asm (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .frame_done(done),
    .frame_word(word)
  );

  tcode_frame_out #(
    .BUF_W(BUF_W)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .load   (done),
    .word   (word),
    .ack    (frame_ack),
    .buf_q  (frame_buf),
    .ready_q(frame_ready)
  );

endmodule

// File: rtl/tcode_pulse_decoder_chk.sv
module tcode_pulse_decoder_chk #(
  parameter int LEN_W = 16,
  parameter int BUF_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             len_valid,
  input logic [LEN_W-1:0] len_ticks,
  input logic             frame_ack,
  input logic [BUF_W-1:0] frame_buf,
  input logic             frame_ready
);

  logic stray_len;
  assign stray_len = (len_ticks == LEN_W'(6)) ||
                     ((len_ticks >= LEN_W'(10)) && (len_ticks <= LEN_W'(39))) ||
                     (len_ticks > LEN_W'(83));

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (frame_buf == '0) && !frame_ready);

  p_short_no_load_r4: assert property (@(posedge clk) disable iff (rst)
    (len_valid && (len_ticks < LEN_W'(3))) |=> $stable(frame_buf));

  p_gap_no_load_r5: assert property (@(posedge clk) disable iff (rst)
    (len_valid && (len_ticks >= LEN_W'(40)) && (len_ticks <= LEN_W'(83)))
      |=> $stable(frame_buf));

  p_stray_no_load_r6: assert property (@(posedge clk) disable iff (rst)
    (len_valid && stray_len) |=> $stable(frame_buf));

  p_load_sets_flag_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(frame_buf) |-> frame_ready);

  p_flag_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (frame_ready && !frame_ack) |=> frame_ready);

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (frame_ack && !len_valid) |=> !frame_ready);

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !len_valid |=> $stable(frame_buf));

endmodule

bind tcode_pulse_decoder tcode_pulse_decoder_chk #(
  .LEN_W(LEN_W),
  .BUF_W(BUF_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .len_valid  (len_valid),
  .len_ticks  (len_ticks),
  .frame_ack  (frame_ack),
  .frame_buf  (frame_buf),
  .frame_ready(frame_ready)
);

// File: tb/sim_tcode_pulse_decoder.sv
module sim_tcode_pulse_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int FBITS      = 59;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic        len_valid;
  logic [15:0] len_ticks;
  logic        frame_ack;
  logic [63:0] frame_buf;
  logic        frame_ready;

  int vectors = 0;
  int misses  = 0;

  // Reference state
  logic [63:0] m_work;
  logic [63:0] m_buf;
  int          m_pos;
  bit          m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcode_pulse_decoder u0 (
    .clk(clk), .rst(rst), .len_valid(len_valid), .len_ticks(len_ticks),
    .frame_ack(frame_ack), .frame_buf(frame_buf), .frame_ready(frame_ready)
  );

  // 0 short, 1 zero, 2 one, 3 gap, 4 stray
  function automatic int classify(input int len);
    if (len < 3)                   return 0;
    if (len <= 5)                  return 1;
    if (len >= 7 && len <= 9)      return 2;
    if (len >= 40 && len <= 83)    return 3;
    return 4;
  endfunction

  function automatic string kind_tag(input int len);
    case (classify(len))
      0: return "R4";
      1: return "R2";
      2: return "R3";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (frame_buf !== m_buf || frame_ready !== m_flag) begin
      misses++;
      $display("FAIL %s: buf=%h ready=%b expected buf=%h ready=%b",
               tag, frame_buf, frame_ready, m_buf, m_flag);
    end
  endtask

  task automatic model_reset();
    m_work = '0; m_buf = '0; m_pos = 0; m_flag = 1'b0;
  endtask

  // Inputs applied on a falling edge, one rising edge, check on next falling edge
  task automatic step(input int len, input bit v, input bit ack, input string tag);
    bit done;
    len_ticks = 16'(len); len_valid = v; frame_ack = ack;
    @(posedge clk);
    done = 1'b0;
    if (v) begin
      case (classify(len))
        1, 2: begin
          m_work[m_pos] = (classify(len) == 2);
          m_pos++;
          if (m_pos >= FBITS) begin
            m_pos = 0; m_buf = m_work; done = 1'b1;
          end
        end
        0, 3: m_pos = 0;
        default: ;
      endcase
    end
    if (done)     m_flag = 1'b1;
    else if (ack) m_flag = 1'b0;
    @(negedge clk);
    compare(done ? "R8" : tag);
    len_valid = 1'b0; frame_ack = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0;
    compare("R1");
  endtask

  task automatic send_frame(input logic [58:0] bits);
    for (int i = 0; i < FBITS; i++) begin
      if (bits[i]) step(int'($urandom_range(7, 9)), 1'b1, 1'b0, "R3");
      else         step(int'($urandom_range(3, 5)), 1'b1, 1'b0, "R2");
    end
    vectors++;
    if (frame_buf !== {5'b0, bits}) begin
      misses++;
      $display("FAIL R7: buf=%h expected=%h", frame_buf, {5'b0, bits});
    end
  endtask

  function automatic int pick_len();
    int r;
    r = int'($urandom_range(0, 99));
    if (r < 45) return int'($urandom_range(3, 5));
    if (r < 90) return int'($urandom_range(7, 9));
    if (r < 93) return int'($urandom_range(0, 2));
    if (r < 95) return int'($urandom_range(40, 83));
    if (r < 97) return (r == 95) ? 6 : int'($urandom_range(10, 39));
    return int'($urandom_range(84, 65535));
  endfunction

  initial begin
    #(CLK_PERIOD * WDOG);
    misses++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [58:0] pat;
    void'($urandom(32'd20240607));
    rst = 1'b1; len_valid = 1'b0; len_ticks = '0; frame_ack = 1'b0;
    model_reset();
    @(negedge clk);
    do_reset();                                   // R1

    step(0, 1'b0, 1'b0, "R10");                   // idle
    send_frame({30{2'b01}} >> 1);                 // R7 alternating
    step(0, 1'b0, 1'b0, "R9");                    // flag holds
    step(0, 1'b0, 1'b1, "R9");                    // clear

    // Partial frame then short pulse: R4 restart
    for (int i = 0; i < 20; i++) step(8, 1'b1, 1'b0, "R3");
    step(2, 1'b1, 1'b0, "R4");
    pat = {$urandom, $urandom};
    send_frame(pat);

    // Partial frame then minute gap: R5 restart
    for (int i = 0; i < 33; i++) step(8, 1'b1, 1'b0, "R3");
    step(40, 1'b1, 1'b0, "R5");
    step(83, 1'b1, 1'b0, "R5");
    pat = {$urandom, $urandom};
    send_frame(pat);

    // Stray lengths mid-frame keep position: R6
    pat = {$urandom, $urandom};
    for (int i = 0; i < FBITS; i++) begin
      step(pat[i] ? 9 : 3, 1'b1, 1'b0, pat[i] ? "R3" : "R2");
      if (i == 10) step(6, 1'b1, 1'b0, "R6");
      if (i == 20) step(10, 1'b1, 1'b0, "R6");
      if (i == 30) step(39, 1'b1, 1'b0, "R6");
      if (i == 40) step(84, 1'b1, 1'b0, "R6");
      if (i == 50) step(65535, 1'b1, 1'b0, "R6");
      if (i == 55) step(0, 1'b0, 1'b0, "R10");
    end

    // Clear on the same edge as frame completion: R9 set wins
    step(0, 1'b0, 1'b1, "R9");
    for (int i = 0; i < FBITS - 1; i++) step(4, 1'b1, 1'b0, "R2");
    step(7, 1'b1, 1'b1, "R9");

    // Reset mid-frame clears position
    for (int i = 0; i < 12; i++) step(5, 1'b1, 1'b0, "R2");
    do_reset();                                   // R1
    pat = {$urandom, $urandom};
    send_frame(pat);

    // Random stream with sporadic clears and idle cycles
    for (int n = 0; n < 4000; n++) begin
      int len;
      len = pick_len();
      step(len, ($urandom_range(0, 9) != 0), ($urandom_range(0, 29) == 0),
           kind_tag(len));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule